// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers up to 32 single-cycle event pulses into a sticky flag register. It qualifies them with a per-source enable register and a one-bit master enable, and drives two outputs toward a processor. The first is a level interrupt request. The processor can hold it back with its own interrupt-disable input. The second is a wake line that pulls a halted processor out of its sleep whenever any enabled flag is pending. The wake line does not look at the master enable.

Software reaches the registers over a simple 16-bit write/read bus. Each 32-bit register appears as a lower and an upper half. A pending flag is acknowledged by writing a one to its bit. Because both outputs are formed from the stored register values, a write to the enable or master-enable register takes effect in the very next cycle. There is no separate re-evaluation step.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, flag and master registers are all zero, every address reads zero, and both `irq` and `wake` are low.
- R2: A pulse on `src_pulse[i]` sets flag bit i on the next clock edge, whatever the enable or master state. Sources 0..15 appear in the lower flag half, with source i at data bit i. Sources 16..31 appear in the upper flag half, at data bit i-16.
- R3: Writing the flag halves clears each bit written as 1. A bit written as 0 keeps its value.
- R4: If a source pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R5: `wake` is high exactly when some bit is set in both enable and flag. It does not depend on the master enable or on `cpu_irq_disable`.
- R6: `irq` is high exactly when the master enable is 1, enable AND flag is nonzero, and `cpu_irq_disable` is low.
- R7: A write to an enable half that overlaps a pending flag while the master enable is 1 raises `irq` in the cycle right after the write edge.
- R8: The master enable stores only data bit 0, and its other bits read as zero. Writing it with bit 0 set while an enabled flag is pending raises `irq` in the cycle right after the write edge.
- R9: While `cpu_irq_disable` is high, `irq` stays low and the pending state is kept. When `cpu_irq_disable` falls, `irq` rises in that same cycle.
- R10: The address map is 0 = enable lower, 1 = enable upper, 2 = flag lower, 3 = flag upper, 4 = master enable. Addresses 5..7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 32 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register half select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cpu_irq_disable | input | 1 | Processor interrupt-disable status; defers `irq` |
| irq | output | 1 | Level interrupt request |
| wake | output | 1 | Halt release, independent of master enable |

## Verification
The assertions check several rules on every cycle. A request never appears without a wake, nor while the master enable is off or the processor mask is set. Every pulsed source holds its flag bit on the following cycle. No flag bit ever rises without a pulse. The bench's scenarios cover what a single-cycle property cannot show: the address map and the read-back of the halves, the acknowledge-by-one rule, the one-cycle reaction to enable and master writes, and the release of a deferred request when the mask falls.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Address of an enable half, a flag half and the master enable for a
  // controller built from 'halves' halves.
  function automatic int unsigned sel_enable(input int unsigned h);
    return h;
  endfunction

  function automatic int unsigned sel_flag(input int unsigned halves, input int unsigned h);
    return halves + h;
  endfunction

  function automatic int unsigned sel_master(input int unsigned halves);
    return 2 * halves;
  endfunction
endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
  import irqc_pkg::*;
#(
  parameter int HALVES = 2,
  parameter int ADDR_W = 3
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [HALVES-1:0] en_we,
  output logic [HALVES-1:0] flag_we,
  output logic              master_we
);
  for (genvar h = 0; h < HALVES; h++) begin : g_sel
    assign en_we[h]   = bus_wr && (bus_addr == ADDR_W'(sel_enable(h)));
    assign flag_we[h] = bus_wr && (bus_addr == ADDR_W'(sel_flag(HALVES, h)));
  end
  assign master_we = bus_wr && (bus_addr == ADDR_W'(sel_master(HALVES)));
endmodule

// File: rtl/irqc_half.sv
module irqc_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         en_we,
  input  logic         flag_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] flag_q
);
  logic [W-1:0] en_nxt;
  logic [W-1:0] flag_nxt;
  logic [W-1:0] ack;

  always_comb begin
    ack      = flag_we ? wdata : '0;
    // A pulse wins over an acknowledge in the same cycle.
    flag_nxt = (flag_q & ~ack) | src;
    en_nxt   = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_nxt;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/irqc_deliver.sv
module irqc_deliver #(
  parameter int N = 32
) (
  input  logic [N-1:0] en_all,
  input  logic [N-1:0] flag_all,
  input  logic         master,
  input  logic         cpu_irq_disable,
  output logic         irq,
  output logic         wake
);
  logic any_enabled;

  always_comb begin
    any_enabled = |(en_all & flag_all);
    wake        = any_enabled;
    irq         = any_enabled && master && !cpu_irq_disable;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int HALVES = 2,
  parameter int SRC_N  = HALF_W * HALVES,
  parameter int ADDR_W = $clog2(2 * HALVES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_pulse,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic              cpu_irq_disable,
  output logic              irq,
  output logic              wake
);
  logic [HALVES-1:0] en_we;
  logic [HALVES-1:0] flag_we;
  logic              master_we;
  logic [SRC_N-1:0]  en_all;
  logic [SRC_N-1:0]  flag_all;
  logic              master_q;
  logic              master_nxt;

  irqc_bus_decode #(.HALVES(HALVES), .ADDR_W(ADDR_W)) i_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .en_we     (en_we),
    .flag_we   (flag_we),
    .master_we (master_we)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    irqc_half #(.W(HALF_W)) i_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_pulse[h*HALF_W +: HALF_W]),
      .en_we   (en_we[h]),
      .flag_we (flag_we[h]),
      .wdata   (bus_wdata),
      .en_q    (en_all[h*HALF_W +: HALF_W]),
      .flag_q  (flag_all[h*HALF_W +: HALF_W])
    );
  end

  always_comb master_nxt = master_we ? bus_wdata[0] : master_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_q <= 1'b0;
    else        master_q <= master_nxt;
  end

  irqc_deliver #(.N(SRC_N)) i_del (
    .en_all          (en_all),
    .flag_all        (flag_all),
    .master          (master_q),
    .cpu_irq_disable (cpu_irq_disable),
    .irq             (irq),
    .wake            (wake)
  );

  always_comb begin
    bus_rdata = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (bus_addr == ADDR_W'(sel_enable(h)))       bus_rdata = en_all[h*HALF_W +: HALF_W];
      if (bus_addr == ADDR_W'(sel_flag(HALVES, h))) bus_rdata = flag_all[h*HALF_W +: HALF_W];
    end
    if (bus_addr == ADDR_W'(sel_master(HALVES))) bus_rdata = {{(HALF_W-1){1'b0}}, master_q};
  end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] src_pulse,
  input logic [N-1:0] flags,
  input logic [N-1:0] enables,
  input logic         master,
  input logic         cpu_mask,
  input logic         irq,
  input logic         wake
);
  a_r6_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);
  a_r6_no_irq_without_master: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !irq);
  a_r9_mask_holds_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask |-> !irq);
  a_r5_wake_on_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|(enables & flags)) |-> wake);
  a_r2_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((flags & $past(src_pulse)) == $past(src_pulse)));
  a_r3_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(src_pulse)) == '0));
endmodule

bind irqc_top irqc_checks #(.N(SRC_N)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_pulse (src_pulse),
  .flags     (flag_all),
  .enables   (en_all),
  .master    (master_q),
  .cpu_mask  (cpu_irq_disable),
  .irq       (irq),
  .wake      (wake)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_pulse = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_irq_disable = 1'b0;
  logic        irq;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_en = '0;
  logic [31:0] m_flag = '0;
  logic        m_master = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq_disable(cpu_irq_disable), .irq(irq), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_en[15:0];
      3'd1: return m_en[31:16];
      3'd2: return m_flag[15:0];
      3'd3: return m_flag[31:16];
      3'd4: return {15'b0, m_master};
      default: return 16'h0;
    endcase
  endfunction

  task automatic compare_all();
    chk("R5 wake", wake, |(m_en & m_flag));
    chk("R6 irq", irq, m_master && (|(m_en & m_flag)) && !cpu_irq_disable);
    chk("R10 rdata", bus_rdata, model_read(bus_addr));
  endtask

  // one clock: model advances with the driven inputs, then compare
  task automatic step();
    logic [31:0] ack;
    logic [31:0] n_flag;
    logic [31:0] n_en;
    logic        n_master;
    ack = '0;
    n_en = m_en;
    n_master = m_master;
    if (bus_wr) begin
      case (bus_addr)
        3'd0: n_en[15:0]  = bus_wdata;
        3'd1: n_en[31:16] = bus_wdata;
        3'd2: ack[15:0]   = bus_wdata;
        3'd3: ack[31:16]  = bus_wdata;
        3'd4: n_master    = bus_wdata[0];
        default: ;
      endcase
    end
    n_flag = (m_flag & ~ack) | src_pulse;
    @(posedge clk);
    #1;
    m_en = n_en; m_flag = n_flag; m_master = n_master;
    compare_all();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] s);
    src_pulse = s;
    step();
    src_pulse = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 16'h0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
    rst_n = 1'b1;
    step();

    // R2: flags set regardless of enables, both halves
    pulse(32'h0010_0008);
    rd(3'd2, v); chk("R2 low half src3", v, 16'h0008);
    rd(3'd3, v); chk("R2 high half src20", v, 16'h0010);
    chk("R5 no wake with enables off", wake, 0);

    // R5: wake with master off
    wr(3'd0, 16'h0008);
    chk("R5 wake with master off", wake, 1);
    chk("R6 irq needs master", irq, 0);

    // R8: only bit 0 of master stored
    wr(3'd4, 16'h0002);
    rd(3'd4, v); chk("R8 master bit1 ignored", v, 16'h0);
    chk("R8 no irq", irq, 0);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); chk("R8 master reads 1", v, 16'h0001);
    chk("R8 irq right after master write", irq, 1);

    // R9: mask defers
    cpu_irq_disable = 1'b1;
    step();
    chk("R9 irq held", irq, 0);
    chk("R9 wake kept", wake, 1);
    cpu_irq_disable = 1'b0;
    #1;
    chk("R9 irq on mask release", irq, 1);

    // R3: acknowledge by one
    wr(3'd2, 16'h0000);
    rd(3'd2, v); chk("R3 zero write keeps", v, 16'h0008);
    wr(3'd2, 16'h0008);
    rd(3'd2, v); chk("R3 one write clears", v, 16'h0000);
    chk("R3 irq drops", irq, 0);
    chk("R3 wake drops", wake, 0);

    // R7: enable write overlapping pending flag
    wr(3'd1, 16'h0010);
    chk("R7 irq right after enable write", irq, 1);

    // R4: pulse beats acknowledge
    bus_addr = 3'd3; bus_wdata = 16'h0010; bus_wr = 1'b1; src_pulse = 32'h0010_0000;
    step();
    bus_wr = 1'b0; src_pulse = '0;
    rd(3'd3, v); chk("R4 pulse wins", v, 16'h0010);
    wr(3'd3, 16'h0010);
    rd(3'd3, v); chk("R4 later clear works", v, 16'h0000);

    // R10: unmapped addresses
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd0, v); chk("R10 enable lo unchanged", v, 16'h0008);
    rd(3'd1, v); chk("R10 enable hi unchanged", v, 16'h0010);
    rd(3'd2, v); chk("R10 flag lo unchanged", v, 16'h0000);
    rd(3'd4, v); chk("R10 master unchanged", v, 16'h0001);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v);
      chk("R10 unmapped reads zero", v, 16'h0);
    end

    // R2: top bits of each half
    pulse(32'h8000_8000);
    rd(3'd2, v); chk("R2 src15", v, 16'h8000);
    rd(3'd3, v); chk("R2 src31", v, 16'h8000);

    // mixed traffic, compared on every clock
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      src_pulse = (r[3:0] == 0) ? (32'h1 << r[8:4]) : '0;
      bus_wr = r[9];
      bus_addr = r[12:10];
      bus_wdata = $urandom;
      cpu_irq_disable = (r[15:13] == 0);
      step();
    end
    bus_wr = 1'b0; src_pulse = '0;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule